// File: doc/BRIEF.md
# Interrupt Masking and Halt Controller

This block gathers the interrupt events of a SCSI bus controller whose transfers are run by a microcoded script sequencer. Each event is recorded in a sticky status bit. The block then decides three things separately. It decides whether the event counts towards a summary pending flag, whether it pulls the active-low host interrupt pin, and whether it asks the sequencer to halt. The sources fall into two groups: bus-side (SCSI) sources and DMA-side sources. Each group has its own enables, status vector, pending flag and clear strobe.

Whether a source is fatal or nonfatal depends on the bus role, initiator or target. A masked nonfatal event only leaves its status bit set. A masked fatal event still halts the sequencer and raises the pending flag, but it leaves the pin alone. The pin is driven by enabled events only, and it stays asserted until the host clears the bank that raised it. Disabling an enable afterwards does not release it.

Top module: `irq_mask_ctrl`

## Requirements
- R1: An event pulse on a source sets that source's status bit at the next clock edge, whether the source is enabled or not. The bit stays set until its bank is cleared.
- R2: A clear strobe (`scsi_clr` or `dma_clr`) empties that bank's status, pending flag and pin contribution at the next edge. An event in the same cycle as the clear survives it.
- R3: SCSI status bit positions are: 0 function complete, 1 selected, 2 reselected, 3 attention raised by the initiator, 4 parity error, 5 bus reset, 6 unexpected disconnect, 7 phase mismatch, 8 general-purpose timer, 9 handshake timer, 10 selection timeout, and 15:11 other fatal causes. With `tgt_mode`=0, bits 0, 1, 2, 8 and 9 are nonfatal and every other bit is fatal.
- R4: With `tgt_mode`=1, bit 3 (attention) is also nonfatal. The other bits keep their initiator classification.
- R5: A masked nonfatal event sets only its status bit. The pending flag, `irq_n` and `halt_req` are unchanged by it.
- R6: A masked fatal event sets its status bit and its bank's pending flag and pulses `halt_req`. It leaves `irq_n` high.
- R7: An enabled nonfatal event sets its status bit and the pending flag and drives `irq_n` low, without `halt_req`.
- R8: An enabled fatal event sets status and pending, drives `irq_n` low and pulses `halt_req`.
- R9: Once `irq_n` is low, changing any enable does not raise it. It goes high only after clears leave no enabled-at-event-time bit in either bank.
- R10: DMA sources use `dma_en` and report in `dma_stat` and `dma_pend`. DMA bit 0 (interrupt-on-the-fly) is nonfatal and DMA bits 7:1 are fatal.
- R11: In target mode, an enabled attention event (bit 3) pulses `halt_req` unless `atn_nohalt`=1. A masked attention event in target mode never halts.
- R12: Events arriving together all set their status bits at the same edge. `halt_req` pulses if any of them would halt.
- R13: `halt_req` and `irq_n` are registered. `halt_req` is high for exactly the one cycle after a halting event. The enables for SCSI bits 7:0 are on `scsi_en_a` and those for bits 15:8 are on `scsi_en_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_mode | input | 1 | Bus role: 0 initiator, 1 target |
| atn_nohalt | input | 1 | In target mode, keeps an enabled attention event from halting |
| scsi_evt | input | 16 | Single-cycle event pulses of the SCSI sources |
| scsi_en_a | input | 8 | Enables for SCSI sources 7:0 |
| scsi_en_b | input | 8 | Enables for SCSI sources 15:8 |
| dma_evt | input | 8 | Single-cycle event pulses of the DMA sources |
| dma_en | input | 8 | Enables for DMA sources |
| scsi_clr | input | 1 | Host read strobe clearing the SCSI bank |
| dma_clr | input | 1 | Host read strobe clearing the DMA bank |
| scsi_stat | output | 16 | Sticky SCSI status bits |
| dma_stat | output | 8 | Sticky DMA status bits |
| scsi_pend | output | 1 | SCSI summary pending flag |
| dma_pend | output | 1 | DMA summary pending flag |
| irq_n | output | 1 | Registered active-low host interrupt |
| halt_req | output | 1 | One-cycle halt request to the sequencer |

## Verification
The assertions assume that event inputs are pulses, sampled once per edge. They also assume that a clear strobe is only meaningful as a whole-bank wipe, and that the role and halt-disable inputs are steady during the cycle in which an event is sampled. The stimulus keeps to these assumptions. It drives every input at the falling edge and re-drives all of them for each cycle, so each event lasts exactly one cycle. It changes `tgt_mode` only between events. Clears are issued either alone or together with a single event, which exercises the case where the event wins over the clear.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
   // SCSI source bit positions
   localparam int SRC_FCMP  = 0;
   localparam int SRC_SEL   = 1;
   localparam int SRC_RESEL = 2;
   localparam int SRC_ATN   = 3;
   localparam int SRC_PAR   = 4;
   localparam int SRC_BRST  = 5;
   localparam int SRC_UDC   = 6;
   localparam int SRC_PHM   = 7;
   localparam int SRC_GPT   = 8;
   localparam int SRC_HTH   = 9;
   localparam int SRC_STO   = 10;
   // DMA source bit positions
   localparam int DSRC_FLY  = 0;

   typedef enum logic {
      ROLE_INIT = 1'b0,
      ROLE_TGT  = 1'b1
   } bus_role_e;
endpackage

// File: rtl/irq_fatal_map.sv
module irq_fatal_map #(
   parameter int          W        = 16,
   parameter logic [W-1:0] NF_INIT = '0,
   parameter logic [W-1:0] NF_TGT  = '0
) (
   input  logic         tgt_mode,
   output logic [W-1:0] fatal
);
   import irq_mask_pkg::*;

   bus_role_e role;
   assign role = bus_role_e'(tgt_mode);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (NF_INIT[i] == NF_TGT[i]) begin : g_fixed
         logic unused_role;
         assign unused_role = tgt_mode;
         assign fatal[i] = ~NF_INIT[i];
      end else begin : g_role
         assign fatal[i] = (role == ROLE_TGT) ? ~NF_TGT[i] : ~NF_INIT[i];
      end
   end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
   parameter int W        = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] en,
   input  logic [W-1:0] fatal,
   input  logic         clr,
   output logic [W-1:0] stat,
   output logic         pend,
   output logic         pin_next
);
   logic [W-1:0] stat_q, stat_d;
   logic [W-1:0] qual_q, qual_d;
   logic [W-1:0] pin_q,  pin_d;
   logic [W-1:0] qual_set, pin_set;

   assign qual_set = evt & (en | fatal);
   assign pin_set  = evt & en;

   if (SET_WINS) begin : g_set_wins
      assign stat_d = evt      | (clr ? '0 : stat_q);
      assign qual_d = qual_set | (clr ? '0 : qual_q);
      assign pin_d  = pin_set  | (clr ? '0 : pin_q);
   end else begin : g_clr_wins
      assign stat_d = clr ? '0 : (stat_q | evt);
      assign qual_d = clr ? '0 : (qual_q | qual_set);
      assign pin_d  = clr ? '0 : (pin_q  | pin_set);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         qual_q <= '0;
         pin_q  <= '0;
      end else begin
         stat_q <= stat_d;
         qual_q <= qual_d;
         pin_q  <= pin_d;
      end
   end

   assign stat     = stat_q;
   assign pend     = |qual_q;
   assign pin_next = |pin_d;
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_req,
   input  logic halt_d,
   output logic irq_n,
   output logic halt_req
);
   logic irq_n_q, halt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_n_q <= 1'b1;
         halt_q  <= 1'b0;
      end else begin
         irq_n_q <= ~pin_req;
         halt_q  <= halt_d;
      end
   end

   assign irq_n    = irq_n_q;
   assign halt_req = halt_q;
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
   parameter int SCSI_W0  = 8,
   parameter int SCSI_W1  = 8,
   parameter int DMA_W    = 8,
   parameter logic [SCSI_W0+SCSI_W1-1:0] NF_INIT_MASK = 'h0307,
   parameter logic [SCSI_W0+SCSI_W1-1:0] NF_TGT_MASK  = 'h030F,
   parameter logic [DMA_W-1:0]           DMA_NF_MASK  = 'h01,
   parameter bit HAS_ATN  = 1'b1,
   parameter int ATN_IDX  = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tgt_mode,
   input  logic                       atn_nohalt,
   input  logic [SCSI_W0+SCSI_W1-1:0] scsi_evt,
   input  logic [SCSI_W0-1:0]         scsi_en_a,
   input  logic [SCSI_W1-1:0]         scsi_en_b,
   input  logic [DMA_W-1:0]           dma_evt,
   input  logic [DMA_W-1:0]           dma_en,
   input  logic                       scsi_clr,
   input  logic                       dma_clr,
   output logic [SCSI_W0+SCSI_W1-1:0] scsi_stat,
   output logic [DMA_W-1:0]           dma_stat,
   output logic                       scsi_pend,
   output logic                       dma_pend,
   output logic                       irq_n,
   output logic                       halt_req
);
   localparam int NS = SCSI_W0 + SCSI_W1;

   if (SCSI_W0 < 1 || SCSI_W1 < 1) begin : g_bad_scsi_w
      $error("irq_mask_ctrl: each SCSI enable group needs at least one bit");
   end
   if (DMA_W < 1) begin : g_bad_dma_w
      $error("irq_mask_ctrl: DMA_W must be at least 1");
   end
   if (HAS_ATN && (ATN_IDX < 0 || ATN_IDX >= NS)) begin : g_bad_atn
      $error("irq_mask_ctrl: ATN_IDX outside the SCSI source range");
   end

   logic [NS-1:0]    scsi_en, scsi_fatal;
   logic [DMA_W-1:0] dma_fatal;
   logic             scsi_pin_nx, dma_pin_nx;
   logic             atn_halt, halt_d;

   assign scsi_en = {scsi_en_b, scsi_en_a};

   irq_fatal_map #(.W(NS), .NF_INIT(NF_INIT_MASK), .NF_TGT(NF_TGT_MASK)) u_scsi_map (
      .tgt_mode (tgt_mode),
      .fatal    (scsi_fatal)
   );

   irq_fatal_map #(.W(DMA_W), .NF_INIT(DMA_NF_MASK), .NF_TGT(DMA_NF_MASK)) u_dma_map (
      .tgt_mode (tgt_mode),
      .fatal    (dma_fatal)
   );

   irq_src_bank #(.W(NS), .SET_WINS(SET_WINS)) u_scsi_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (scsi_evt),
      .en       (scsi_en),
      .fatal    (scsi_fatal),
      .clr      (scsi_clr),
      .stat     (scsi_stat),
      .pend     (scsi_pend),
      .pin_next (scsi_pin_nx)
   );

   irq_src_bank #(.W(DMA_W), .SET_WINS(SET_WINS)) u_dma_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (dma_evt),
      .en       (dma_en),
      .fatal    (dma_fatal),
      .clr      (dma_clr),
      .stat     (dma_stat),
      .pend     (dma_pend),
      .pin_next (dma_pin_nx)
   );

   if (HAS_ATN) begin : g_atn
      assign atn_halt = tgt_mode & ~atn_nohalt & scsi_evt[ATN_IDX] & scsi_en[ATN_IDX];
   end else begin : g_no_atn
      logic unused_nohalt;
      assign unused_nohalt = atn_nohalt;
      assign atn_halt = 1'b0;
   end

   assign halt_d = (|(scsi_evt & scsi_fatal)) | (|(dma_evt & dma_fatal)) | atn_halt;

   irq_out_stage u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_req  (scsi_pin_nx | dma_pin_nx),
      .halt_d   (halt_d),
      .irq_n    (irq_n),
      .halt_req (halt_req)
   );
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
   parameter int NS = 16,
   parameter int ND = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [NS-1:0] scsi_evt,
   input logic [ND-1:0] dma_evt,
   input logic          scsi_clr,
   input logic          dma_clr,
   input logic [NS-1:0] scsi_stat,
   input logic [ND-1:0] dma_stat,
   input logic          scsi_pend,
   input logic          dma_pend,
   input logic          irq_n,
   input logic          halt_req
);
   logic evt_any;
   assign evt_any = (scsi_evt != '0) || (dma_evt != '0);

   p_stat_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (scsi_evt != '0) |=> ((scsi_stat & $past(scsi_evt)) == $past(scsi_evt)));

   p_dma_stat_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_evt != '0) |=> ((dma_stat & $past(dma_evt)) == $past(dma_evt)));

   p_clear_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (scsi_clr && scsi_evt == '0) |=> (scsi_stat == '0 && !scsi_pend));

   p_pin_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !scsi_clr && !dma_clr) |=> !irq_n);

   p_pin_has_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (scsi_pend || dma_pend));

   p_pend_has_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      scsi_pend |-> (scsi_stat != '0));

   p_halt_has_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> $past(evt_any));
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.NS(SCSI_W0 + SCSI_W1), .ND(DMA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scsi_evt  (scsi_evt),
   .dma_evt   (dma_evt),
   .scsi_clr  (scsi_clr),
   .dma_clr   (dma_clr),
   .scsi_stat (scsi_stat),
   .dma_stat  (dma_stat),
   .scsi_pend (scsi_pend),
   .dma_pend  (dma_pend),
   .irq_n     (irq_n),
   .halt_req  (halt_req)
);

// File: tb/sim_irq_mask_ctrl.sv
module sim_irq_mask_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tgt_mode = 1'b0, atn_nohalt = 1'b0;
   logic [15:0] scsi_evt = '0;
   logic [7:0]  scsi_en_a = '0, scsi_en_b = '0;
   logic [7:0]  dma_evt = '0, dma_en = '0;
   logic        scsi_clr = 1'b0, dma_clr = 1'b0;
   logic [15:0] scsi_stat;
   logic [7:0]  dma_stat;
   logic        scsi_pend, dma_pend, irq_n, halt_req;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_mask_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .tgt_mode(tgt_mode), .atn_nohalt(atn_nohalt),
      .scsi_evt(scsi_evt), .scsi_en_a(scsi_en_a), .scsi_en_b(scsi_en_b),
      .dma_evt(dma_evt), .dma_en(dma_en), .scsi_clr(scsi_clr), .dma_clr(dma_clr),
      .scsi_stat(scsi_stat), .dma_stat(dma_stat), .scsi_pend(scsi_pend),
      .dma_pend(dma_pend), .irq_n(irq_n), .halt_req(halt_req)
   );

   typedef struct {
      logic [15:0] s;
      logic [7:0]  d;
      logic        sp, dp, irqn, halt;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   // reference state, written from the requirements
   logic [15:0] m_s = '0, m_qs = '0, m_ps = '0;
   logic [7:0]  m_d = '0, m_qd = '0, m_pd = '0;

   task automatic step(input logic [15:0] se, input logic [7:0] de,
                       input logic [15:0] sen, input logic [7:0] den,
                       input logic tgt, input logic nh,
                       input logic sc, input logic dc, input string tag);
      logic [15:0] nf_s, fat_s;
      logic [7:0]  fat_d;
      exp_t e;
      @(negedge clk);
      scsi_evt = se; dma_evt = de; scsi_en_a = sen[7:0]; scsi_en_b = sen[15:8];
      dma_en = den; tgt_mode = tgt; atn_nohalt = nh; scsi_clr = sc; dma_clr = dc;
      nf_s  = tgt ? 16'h030F : 16'h0307;   // R3, R4
      fat_s = ~nf_s;
      fat_d = 8'hFE;                        // R10
      if (sc) begin m_s = '0; m_qs = '0; m_ps = '0; end
      if (dc) begin m_d = '0; m_qd = '0; m_pd = '0; end
      m_s  |= se;  m_qs |= se & (sen | fat_s); m_ps |= se & sen;
      m_d  |= de;  m_qd |= de & (den | fat_d); m_pd |= de & den;
      e.s = m_s; e.d = m_d; e.sp = |m_qs; e.dp = |m_qd;
      e.irqn = ~(|m_ps | |m_pd);
      e.halt = (|(se & fat_s)) | (|(de & fat_d)) | (tgt & ~nh & se[3] & sen[3]);
      e.tag = tag;
      @(posedge clk);
      #1 exp_q.push_back(e);
   endtask

   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_chk++;
         if (scsi_stat !== e.s || dma_stat !== e.d || scsi_pend !== e.sp ||
             dma_pend !== e.dp || irq_n !== e.irqn || halt_req !== e.halt) begin
            n_bad++;
            $display("FAIL %s: got s=%h d=%h sp=%b dp=%b irqn=%b halt=%b exp s=%h d=%h sp=%b dp=%b irqn=%b halt=%b",
                     e.tag, scsi_stat, dma_stat, scsi_pend, dma_pend, irq_n, halt_req,
                     e.s, e.d, e.sp, e.dp, e.irqn, e.halt);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if (scsi_stat !== '0 || dma_stat !== '0 || scsi_pend !== 1'b0 ||
          dma_pend !== 1'b0 || irq_n !== 1'b1 || halt_req !== 1'b0) begin
         n_bad++;
         $display("FAIL R13 reset: got s=%h d=%h sp=%b dp=%b irqn=%b halt=%b exp all idle",
                  scsi_stat, dma_stat, scsi_pend, dma_pend, irq_n, halt_req);
      end
      rst_n = 1'b1;
      // initiator role
      step(16'h0001, 8'h00, 16'h0000, 8'h00, 0, 0, 0, 0, "R5 masked nonfatal");
      step(16'h0010, 8'h00, 16'h0000, 8'h00, 0, 0, 0, 0, "R6 masked fatal");
      step(16'h0000, 8'h00, 16'h0000, 8'h00, 0, 0, 1, 0, "R2 scsi clear");
      step(16'h0002, 8'h00, 16'h0002, 8'h00, 0, 0, 0, 0, "R7 enabled nonfatal");
      step(16'h0000, 8'h00, 16'h0000, 8'h00, 0, 0, 0, 0, "R9 enable dropped, pin held");
      step(16'h0000, 8'h00, 16'h0000, 8'h00, 0, 0, 1, 0, "R9 clear releases pin");
      step(16'h0010, 8'h00, 16'h0010, 8'h00, 0, 0, 0, 0, "R8 enabled fatal");
      step(16'h0000, 8'h00, 16'h0000, 8'h00, 0, 0, 1, 0, "R2 clear after fatal");
      step(16'h0008, 8'h00, 16'h0000, 8'h00, 0, 0, 0, 0, "R3 attention fatal as initiator");
      step(16'h0000, 8'h00, 16'h0000, 8'h00, 0, 0, 1, 0, "R2 clear");
      // target role
      step(16'h0008, 8'h00, 16'h0000, 8'h00, 1, 0, 0, 0, "R4 attention nonfatal as target");
      step(16'h0008, 8'h00, 16'h0008, 8'h00, 1, 0, 0, 0, "R11 enabled attention halts");
      step(16'h0000, 8'h00, 16'h0000, 8'h00, 1, 0, 1, 0, "R2 clear");
      step(16'h0008, 8'h00, 16'h0008, 8'h00, 1, 1, 0, 0, "R11 halt disabled");
      step(16'h0000, 8'h00, 16'h0000, 8'h00, 1, 0, 1, 0, "R2 clear");
      step(16'h0320, 8'h00, 16'h0000, 8'h00, 1, 0, 0, 0, "R12 timers plus bus reset together");
      step(16'h0000, 8'h00, 16'h0000, 8'h00, 1, 0, 1, 0, "R2 clear");
      // DMA bank
      step(16'h0000, 8'h01, 16'h0000, 8'h01, 0, 0, 0, 0, "R10 enabled DMA nonfatal");
      step(16'h0000, 8'h04, 16'h0000, 8'h00, 0, 0, 0, 0, "R10 masked DMA fatal");
      step(16'h0000, 8'h08, 16'h0000, 8'h00, 0, 0, 0, 1, "R2 event beats clear");
      step(16'h0000, 8'h00, 16'h0000, 8'h00, 0, 0, 0, 1, "R2 DMA clear");
      // stickiness and halt pulse width
      step(16'h0400, 8'h00, 16'h0000, 8'h00, 0, 0, 0, 0, "R1 masked timeout recorded");
      step(16'h0000, 8'h00, 16'hFFFF, 8'hFF, 0, 0, 0, 0, "R1 R13 sticky, halt one cycle");
      step(16'h0000, 8'h00, 16'h0000, 8'h00, 0, 0, 0, 0, "R1 still sticky");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule